// File: doc/BRIEF.md
# Rising-Edge Manchester Line Decoder

This block takes a single-wire Manchester-coded line and turns it back into a serial bit stream. A one is a low-to-high transition in the middle of its bit cell and a zero is a high-to-low transition in the middle of its cell. The block can only see rising transitions. It therefore measures, in local ticks, how long the line goes between two rising edges, and from that interval and the last decoded bit it infers how many bits have passed. This includes zeros that left no visible edge. Every interval is judged against windows about one quarter-period wide on each side, so a moderate rate mismatch between sender and receiver clocks is absorbed.

The timing unit is the quarter-period Q, counted in enabled ticks (`tickEn`). A bit cell lasts 4Q. The line idles low. A message always begins with a one, so the first rising edge marks the middle of bit 0. A message always ends with a zero; the sender appends one if needed. If no rising edge arrives for 9Q, the block closes the message. It emits the final zero if that zero could not be seen, pulses `eom` and goes back to waiting for the next first edge.

Top module: `rmd_decoder`

## Requirements
- R1: After reset `dataValid` and `eom` are 0, and while the line stays low no `dataValid` or `eom` is produced.
- R2: The first rising edge after idle produces one `dataValid` with `dataBit` = 1 and arms the decoder.
- R3: With the last decoded bit a one, an interval in the short bin produces a single 1.
- R4: With the last decoded bit a one, an interval in the middle bin produces a 0 and then a 0, and the decoder then counts the last bit as a zero.
- R5: With the last decoded bit a one, an interval in the long bin produces a 0 and then a 1.
- R6: With the last decoded bit a zero, a short-bin interval produces a 0 and any longer interval produces a 1.
- R7: Intervals are binned in enabled ticks: fewer than 5Q is short, 5Q up to below 7Q is middle, and 7Q or more is long. Messages are decoded correctly when the sender's quarter period is anywhere within ±10% of Q.
- R8: Falling edges on the line produce no output.
- R9: When the armed decoder sees no rising edge for 9Q ticks, it pulses `eom` for one cycle and returns to idle. If the last decoded bit was a one, a `dataValid` with `dataBit` = 0 is given in the same cycle as `eom`.
- R10: Interval measurement advances only on cycles with `tickEn` = 1, so Q is measured in enabled ticks and not in clock cycles.
- R11: The two bits produced by one interval appear on consecutive cycles, and `dataValid` is never high in the cycle after `eom`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Local time base; one tick per cycle in which it is high |
| lineIn | input | 1 | Manchester-coded line, idle low |
| dataValid | output | 1 | Strobe for one decoded bit |
| dataBit | output | 1 | Decoded bit value, valid when `dataValid` is high |
| eom | output | 1 | One-cycle end-of-message pulse |

## Verification
The assertions assume the line carries only legal Manchester traffic. Rising edges are therefore always at least about 3Q ticks apart. This means a second pending bit is always drained before the next edge, and a fresh edge never lands right after an end-of-message. The assertions also assume every message starts with a one and ends with a zero. The stimulus meets these assumptions by encoding only such messages. The sender's quarter period is held within ±10% of Q, and every message is followed by at least 12Q of low idle line. Half-rate `tickEn` runs use a doubled sender period, so the interval in ticks stays the same.

// File: rtl/rmd_pkg.sv
package rmd_pkg;

  // Decoder phase: where the last rising edge left the bit stream.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for the first edge of a message
    ST_ONE  = 2'd1,  // last edge was the middle of a one
    ST_ZERO = 2'd2   // last edge was the start of a zero cell
  } decState_t;

  // Measurement results handed from datapath to control.
  typedef struct packed {
    logic rise;      // synchronised rising edge this cycle
    logic binShort;  // interval below the short/middle threshold
    logic binMid;    // interval in the middle bin
    logic timeout;   // interval just reached the end-of-message limit
  } decFlags_t;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic clrCnt;
    logic firstVld;
    logic firstBit;
    logic secondVld;
    logic secondBit;
    logic endMsg;
  } decStrobe_t;

endpackage

// File: rtl/rmd_datapath.sv
module rmd_datapath
  import rmd_pkg::*;
#(
  parameter int Q_TICKS     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       lineIn,
  input  decStrobe_t strobe,
  output decFlags_t  flags,
  output logic       dataValid,
  output logic       dataBit,
  output logic       eom
);

  localparam int LIMIT_TICKS = 9 * Q_TICKS;
  localparam int SHORT_TICKS = 5 * Q_TICKS;
  localparam int MID_TICKS   = 7 * Q_TICKS;
  localparam int CW          = $clog2(LIMIT_TICKS + 2);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT_TICKS);
  localparam logic [CW-1:0] SAT_C   = CW'(LIMIT_TICKS + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] MID_C   = CW'(MID_TICKS);

  // Synchroniser chain plus one extra stage holding the previous level.
  logic [SYNC_STAGES:0] syncQ;
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-1:0], lineIn};
  end

  logic riseDet;
  assign riseDet = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Tick counter since the last rising edge, saturating one past the limit.
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (strobe.clrCnt)         cnt <= '0;
    else if (tickEn && cnt != SAT_C) cnt <= cnt + 1'b1;
  end

  always_comb begin
    flags.rise     = riseDet;
    flags.binShort = (cnt < SHORT_C);
    flags.binMid   = (cnt >= SHORT_C) && (cnt < MID_C);
    flags.timeout  = tickEn && (cnt == LIMIT_C);
  end

  // Output stage with a one-deep slot for the second bit of a pair.
  logic pendVld, pendBit;
  always_ff @(posedge clk) begin
    if (rst) begin
      dataValid <= 1'b0;
      dataBit   <= 1'b0;
      pendVld   <= 1'b0;
      pendBit   <= 1'b0;
      eom       <= 1'b0;
    end else begin
      dataValid <= strobe.firstVld | pendVld;
      dataBit   <= strobe.firstVld ? strobe.firstBit : (pendVld & pendBit);
      pendVld   <= strobe.secondVld;
      pendBit   <= strobe.secondBit;
      eom       <= strobe.endMsg;
    end
  end

  a_r11_pend_single: assert property (@(posedge clk) disable iff (rst)
    pendVld |=> !pendVld);

  a_r11_pair_back_to_back: assert property (@(posedge clk) disable iff (rst)
    pendVld |-> dataValid);

  a_r11_eom_gap: assert property (@(posedge clk) disable iff (rst)
    eom |=> !dataValid);

  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!tickEn && !strobe.clrCnt) |=> $stable(cnt));

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= SAT_C);

  a_r8_valid_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(dataValid) |-> $past(flags.rise || flags.timeout));

endmodule

// File: rtl/rmd_control.sv
module rmd_control
  import rmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  decFlags_t  flags,
  output decStrobe_t strobe,
  output logic       idle
);

  decState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    strobe.clrCnt = flags.rise;
    unique case (state)
      ST_IDLE: begin
        if (flags.rise) begin
          strobe.firstVld = 1'b1;
          strobe.firstBit = 1'b1;
          stateNxt        = ST_ONE;
        end
      end
      ST_ONE: begin
        if (flags.rise) begin
          strobe.firstVld = 1'b1;
          if (flags.binShort) begin
            strobe.firstBit = 1'b1;
          end else if (flags.binMid) begin
            strobe.secondVld = 1'b1;
            strobe.secondBit = 1'b0;
            stateNxt         = ST_ZERO;
          end else begin
            strobe.secondVld = 1'b1;
            strobe.secondBit = 1'b1;
          end
        end else if (flags.timeout) begin
          strobe.firstVld = 1'b1;
          strobe.firstBit = 1'b0;
          strobe.endMsg   = 1'b1;
          stateNxt        = ST_IDLE;
        end
      end
      ST_ZERO: begin
        if (flags.rise) begin
          strobe.firstVld = 1'b1;
          strobe.firstBit = !flags.binShort;
          if (!flags.binShort) stateNxt = ST_ONE;
        end else if (flags.timeout) begin
          strobe.endMsg = 1'b1;
          stateNxt      = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign idle = (state == ST_IDLE);

  a_r2_arm_on_first_edge: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && flags.rise) |=> state == ST_ONE);

  a_r4_mid_bin_to_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ONE && flags.rise && flags.binMid) |=> state == ST_ZERO);

  a_r9_timeout_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && flags.timeout && !flags.rise) |=> state == ST_IDLE);

  a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !flags.rise) |=> state == ST_IDLE);

endmodule

// File: rtl/rmd_decoder.sv
module rmd_decoder
  import rmd_pkg::*;
#(
  parameter int Q_TICKS     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tickEn,
  input  logic lineIn,
  output logic dataValid,
  output logic dataBit,
  output logic eom
);

  decFlags_t  flags;
  decStrobe_t strobe;
  logic       idle;

  rmd_datapath #(
    .Q_TICKS    (Q_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .lineIn   (lineIn),
    .strobe   (strobe),
    .flags    (flags),
    .dataValid(dataValid),
    .dataBit  (dataBit),
    .eom      (eom)
  );

  rmd_control control_i (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .strobe(strobe),
    .idle  (idle)
  );

  a_r2_first_bit_one: assert property (@(posedge clk) disable iff (rst)
    (idle && flags.rise) |=> (dataValid && dataBit));

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (idle && !flags.rise) |=> !eom);

endmodule

// File: tb/rmd_decoder_tb_top.sv
`timescale 1ns/1ps
module rmd_decoder_tb_top;

  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b1;
  logic lineIn = 1'b0;
  logic dataValid, dataBit, eom;

  always #2 clk = ~clk;

  rmd_decoder #(.Q_TICKS(Q)) dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .lineIn(lineIn),
    .dataValid(dataValid), .dataBit(dataBit), .eom(eom)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit halfRate = 1'b0;
  bit finished = 1'b0;

  logic [31:0] gotBits;
  int gotLen = 0;
  int validCyc [0:31];
  int eomCnt = 0;
  int lastEomCyc = -10;
  int eomGapBad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (halfRate) tickEn <= ~tickEn;
    else          tickEn <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (dataValid) begin
        if (gotLen < 32) begin
          gotBits[gotLen]  = dataBit;
          validCyc[gotLen] = cyc;
        end
        gotLen++;
        if (lastEomCyc == cyc - 1) eomGapBad++;
      end
      if (eom) begin
        eomCnt++;
        lastEomCyc = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    gotBits = '0;
    gotLen  = 0;
    eomCnt  = 0;
    eomGapBad = 0;
  endtask

  // Drive one message, bit 0 first; then hold the line low for 12Q.
  task automatic sendMsg(input logic [31:0] bits, input int len, input int qCyc);
    for (int i = 0; i < len; i++) begin
      lineIn = ~bits[i];
      repeat (2 * qCyc) @(negedge clk);
      lineIn = bits[i];
      repeat (2 * qCyc) @(negedge clk);
    end
    lineIn = 1'b0;
    repeat (12 * qCyc) @(negedge clk);
  endtask

  function automatic logic [31:0] maskLen(input logic [31:0] v, input int len);
    return v & ((32'd1 << len) - 32'd1);
  endfunction

  task automatic runMsg(input logic [31:0] bits, input int len, input int qCyc,
                        input string req);
    clearMon();
    sendMsg(bits, len, qCyc);
    check(gotLen == len, req, "bit count", gotLen, len);
    check(maskLen(gotBits, len) == maskLen(bits, len), req, "bits",
          maskLen(gotBits, len), maskLen(bits, len));
    check(eomCnt == 1 && eomGapBad == 0, "R9/R11", "eom framing",
          eomCnt + 16 * eomGapBad, 1);
  endtask

  function automatic logic [31:0] randMsg(input int len);
    logic [31:0] m;
    m = $urandom();
    m[0] = 1'b1;
    m[len-1] = 1'b0;
    return m;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0C0D));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and a quiet idle line
    check(dataValid == 1'b0 && eom == 1'b0, "R1", "reset outputs", {dataValid, eom}, 0);
    clearMon();
    repeat (600) @(negedge clk);
    check(gotLen == 0 && eomCnt == 0, "R1", "idle silence", gotLen + eomCnt, 0);

    // R2, R3: "110" (1, short interval -> 1, trailing zero)
    runMsg(32'b011, 3, Q, "R2/R3");
    // R4 and R11: "100" (middle interval gives two zeros back to back)
    runMsg(32'b001, 3, Q, "R4");
    check(gotLen >= 3 && validCyc[2] - validCyc[1] == 1, "R11", "pair spacing",
          validCyc[2] - validCyc[1], 1);
    // R5: "1010" (long interval gives 0 then 1)
    runMsg(32'b0101, 4, Q, "R5");
    // R6: "1000110" exercises both zero-state bins
    runMsg(32'b0110001, 7, Q, "R6");
    // R9: "10" trailing zero appears with eom
    runMsg(32'b01, 2, Q, "R9");
    check(gotLen == 2 && validCyc[1] == lastEomCyc, "R9", "trailing zero with eom",
          validCyc[1], lastEomCyc);

    // R8: after the falling edge of "10", only the first bit has been seen
    clearMon();
    fork
      sendMsg(32'b01, 2, Q);
      begin
        repeat (8 * Q + 3) @(negedge clk);
        check(gotLen == 1, "R8", "falling edge ignored", gotLen, 1);
      end
    join

    // R7: drift corners at -10% and +10%
    runMsg(32'b0110101001, 10, 36, "R7");
    runMsg(32'b0110101001, 10, 44, "R7");
    runMsg(32'b0100110001, 10, 44, "R7");

    // R3/R4/R5/R6/R7: random messages with random sender drift
    for (int n = 0; n < 30; n++) begin
      int len  = 2 + int'($urandom_range(8));
      int qCyc = 36 + int'($urandom_range(8));
      runMsg(randMsg(len), len, qCyc, "R3/R4/R5/R6/R7");
    end

    // R10: half-rate ticks with a doubled sender period
    halfRate = 1'b1;
    for (int n = 0; n < 5; n++) begin
      int len  = 2 + int'($urandom_range(6));
      int qCyc = 72 + int'($urandom_range(16));
      runMsg(randMsg(len), len, qCyc, "R10");
    end
    halfRate = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule